// File: doc/BRIEF.md
# In-Band Loopback Code Detector

This block watches the recovered unipolar T1 receive bit stream for two programmable repeating codes, one requesting loop-up (activate) and one requesting loop-down (deactivate). Each code is 4 to 7 bits long. A shorter code is entered by writing it out twice, so a 3-bit deactivate code such as 001 is programmed as the 6-bit value 001001. The stream may be caught in any phase of the code.

Each code has its own matcher. A received bit counts as a match when it equals the bit received one code length earlier and the most recent code-length window is a rotation of the programmed pattern. After a programmable number of consecutive matching bits, the matcher reports a detection once. The detection sets a sticky status bit and a sticky interrupt-status bit for that code. The interrupt output is the OR of the interrupt-status bits whose enable is set.

The detector only reports. The processor that services the interrupt decides whether to open or close a loopback. Matching runs only while the line is in T1 mode.

Top module: `inband_code_detect`

## Requirements
- R1: Out of reset, det_stat, int_stat and irq are all zero.
- R2: A length select of 0, 1, 2 or 3 gives a code length L of 4, 5, 6 or 7 bits. Code bits [L-1:0] are used and bit L-1 is the first bit on the line. Code bits above L-1 have no effect.
- R3: A bit matches when it equals the bit accepted L bits earlier and the last L accepted bits (it included) equal some rotation of the code. A code's status is set at the clock edge that accepts its match_thresh-th consecutive matching bit.
- R4: Only bits presented with bit_valid high are examined. Cycles with bit_valid low neither count nor break a run, whatever bit_data holds.
- R5: A non-matching accepted bit resets that code's run to zero. A new detection needs match_thresh fresh consecutive matches.
- R6: The two matchers (index 0 = activate, 1 = deactivate) run independently and can both detect from the same stream.
- R7: det_stat[i] stays set until a clr_det[i] cycle, and int_stat[i] stays set until a clr_int[i] cycle. If a detection and a clear land in the same cycle, the bit is set.
- R8: irq is high exactly when some int_stat[i] is set with irq_en[i] high. irq_en does not change int_stat.
- R9: While t1_mode is low, nothing is detected, and the run counters and bit history are cleared.
- R10: A 3-bit code written twice as a 6-bit code is detected on a stream repeating the 3-bit code.
- R11: While a code keeps arriving after its detection, no further detection is reported. A status bit cleared during the code stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t1_mode | input | 1 | High when the line runs at the T1 rate; enables matching |
| bit_valid | input | 1 | Strobe marking bit_data as a received bit |
| bit_data | input | 1 | Recovered unipolar data bit |
| up_code | input | 7 | Activate code pattern, bit L-1 sent first |
| up_len | input | 2 | Activate code length select (L = 4 + value) |
| dn_code | input | 7 | Deactivate code pattern, bit L-1 sent first |
| dn_len | input | 2 | Deactivate code length select (L = 4 + value) |
| match_thresh | input | CNT_W | Consecutive matching bits required for detection (at least 1) |
| irq_en | input | 2 | Interrupt enables, bit 0 activate, bit 1 deactivate |
| clr_det | input | 2 | Clear strobes for det_stat |
| clr_int | input | 2 | Clear strobes for int_stat |
| det_stat | output | 2 | Sticky detection status, bit 0 loop-up, bit 1 loop-down |
| int_stat | output | 2 | Sticky interrupt status per code |
| irq | output | 1 | Interrupt request (alarm summary) |

## Verification
Each code is sent from an arbitrary starting phase to show that detection does not depend on alignment. A 5-bit activate code and a 7-bit code cover the length selects. A 3-bit code written twice checks the doubled-entry rule. Several other stimuli each separate one behaviour:
- Invalid cycles carrying noise between valid bits separate strobe gating from data.
- A single flipped bit in mid-run separates a restart of the run from a run that merely pauses.
- An alternating 01 stream matches a 4-bit code (with garbage in its unused upper bits) and a 6-bit code at once, which shows the matchers are independent.
- Clears held during a fresh detection, clears during a long-running code, and a stream sent with T1 mode off cover the set-wins, no-retrigger and T1-only rules.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

  localparam int unsigned IBC_LEN_SEL_W = 2;
  localparam int unsigned IBC_MIN_LEN   = 4;
  localparam int unsigned IBC_CODE_W    = IBC_MIN_LEN + (1 << IBC_LEN_SEL_W) - 1;
  localparam int unsigned IBC_IDX_W     = $clog2(IBC_CODE_W);
  localparam int unsigned IBC_NUM_CODES = 2;
  localparam int unsigned IBC_UP        = 0;
  localparam int unsigned IBC_DN        = 1;

  typedef logic [IBC_CODE_W-1:0]    code_t;
  typedef logic [IBC_LEN_SEL_W-1:0] len_sel_t;

  // Code length in bits from its select field.
  function automatic int unsigned code_len(len_sel_t sel);
    return IBC_MIN_LEN + 32'(sel);
  endfunction

  // True when the new bit repeats the bit accepted len positions earlier.
  // hist[0] is the previous accepted bit.
  function automatic logic is_periodic(logic b, code_t hist, int unsigned len);
    logic r;
    r = 1'b0;
    for (int unsigned i = 0; i < IBC_CODE_W; i++) begin
      if (i + 1 == len) r = (hist[i] == b);
    end
    return r;
  endfunction

  // True when the low len bits of win (newest at bit 0) equal some rotation
  // of the low len bits of pat.
  function automatic logic in_phase(code_t win, code_t pat, int unsigned len);
    logic             any;
    logic             ok;
    logic [IBC_IDX_W:0] idx;
    any = 1'b0;
    for (int unsigned k = 0; k < IBC_CODE_W; k++) begin
      if (k < len) begin
        ok = 1'b1;
        for (int unsigned i = 0; i < IBC_CODE_W; i++) begin
          if (i < len) begin
            idx = (IBC_IDX_W+1)'(i + k);
            if (32'(idx) >= len) idx = idx - (IBC_IDX_W+1)'(len);
            if (win[i] != pat[idx[IBC_IDX_W-1:0]]) ok = 1'b0;
          end
        end
        if (ok) any = 1'b1;
      end
    end
    return any;
  endfunction

endpackage

// File: rtl/ibc_bit_history.sv
module ibc_bit_history #(
  parameter int unsigned HIST_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              accept,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (!enable) begin
      hist_q <= '0;
    end else if (accept) begin
      hist_q <= {hist_q[HIST_W-2:0], bit_in};
    end
  end

  assign hist_o = hist_q;

  // R4: an accepted bit becomes the newest history entry
  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && accept) |=> (hist_o[0] == $past(bit_in)));

  // R4: cycles without a strobe leave the history untouched
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !accept) |=> $stable(hist_o));

  // R9: leaving T1 mode empties the history
  p_hist_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hist_o == '0));

endmodule

// File: rtl/ibc_code_matcher.sv
module ibc_code_matcher
  import ibc_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             accept,
  input  logic             bit_in,
  input  code_t            hist,
  input  code_t            pattern,
  input  len_sel_t         len_sel,
  input  logic [CNT_W-1:0] thresh,
  output logic             hit_o,
  output logic             onset_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  int unsigned      len;
  code_t            window;
  logic             periodic;
  logic             phased;
  logic             below;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;

  always_comb begin
    len       = code_len(len_sel);
    window    = {hist[IBC_CODE_W-2:0], bit_in};
    periodic  = is_periodic(bit_in, hist, len);
    phased    = in_phase(window, pattern, len);
    hit_o     = enable && accept && periodic && phased;
    below     = (count_q < thresh);
    count_inc = count_q + CNT_ONE;
    onset_o   = hit_o && below && (count_inc == thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!enable) begin
      count_q <= '0;
    end else if (accept) begin
      if (!hit_o)     count_q <= '0;
      else if (below) count_q <= count_inc;
    end
  end

  assign count_o = count_q;

  // R5: a rejected bit restarts the run
  p_miss_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && accept && !hit_o) |=> (count_o == '0));

  // R4: detection only happens on a strobed bit
  p_onset_strobed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    onset_o |-> (accept && enable));

  // R3: the detecting edge leaves the run at the threshold
  p_onset_at_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    onset_o |=> (count_o == $past(thresh)));

  // R11: a run already at the threshold never reports again
  p_no_repeat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == thresh) |-> !onset_o);

endmodule

// File: rtl/ibc_report.sv
module ibc_report #(
  parameter int unsigned NUM_CODES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CODES-1:0] onset,
  input  logic [NUM_CODES-1:0] clr_det,
  input  logic [NUM_CODES-1:0] clr_int,
  input  logic [NUM_CODES-1:0] int_en,
  output logic [NUM_CODES-1:0] det_stat,
  output logic [NUM_CODES-1:0] int_stat,
  output logic                 irq
);

  logic [NUM_CODES-1:0] det_q;
  logic [NUM_CODES-1:0] int_q;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        det_q[i] <= 1'b0;
        int_q[i] <= 1'b0;
      end else begin
        // a detection overrides a clear in the same cycle
        if (onset[i])        det_q[i] <= 1'b1;
        else if (clr_det[i]) det_q[i] <= 1'b0;
        if (onset[i])        int_q[i] <= 1'b1;
        else if (clr_int[i]) int_q[i] <= 1'b0;
      end
    end

    // R7: status holds until its own clear
    p_det_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (det_stat[i] && !clr_det[i]) |=> det_stat[i]);

    p_int_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_stat[i] && !clr_int[i]) |=> int_stat[i]);

    // R7: a detection always lands, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      onset[i] |=> (det_stat[i] && int_stat[i]));

    // R8: an enabled new interrupt status raises the request
    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(int_stat[i]) && int_en[i]) |-> irq);
  end

  assign det_stat = det_q;
  assign int_stat = int_q;
  assign irq      = |(int_q & int_en);

endmodule

// File: rtl/inband_code_detect.sv
module inband_code_detect
  import ibc_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     t1_mode,
  input  logic                     bit_valid,
  input  logic                     bit_data,
  input  logic [IBC_CODE_W-1:0]    up_code,
  input  logic [IBC_LEN_SEL_W-1:0] up_len,
  input  logic [IBC_CODE_W-1:0]    dn_code,
  input  logic [IBC_LEN_SEL_W-1:0] dn_len,
  input  logic [CNT_W-1:0]         match_thresh,
  input  logic [IBC_NUM_CODES-1:0] irq_en,
  input  logic [IBC_NUM_CODES-1:0] clr_det,
  input  logic [IBC_NUM_CODES-1:0] clr_int,
  output logic [IBC_NUM_CODES-1:0] det_stat,
  output logic [IBC_NUM_CODES-1:0] int_stat,
  output logic                     irq
);

  code_t                   hist_w;
  code_t                   pat_w   [IBC_NUM_CODES];
  len_sel_t                len_w   [IBC_NUM_CODES];
  logic [CNT_W-1:0]        count_w [IBC_NUM_CODES];
  logic [IBC_NUM_CODES-1:0] hit_w;
  logic [IBC_NUM_CODES-1:0] onset_w;

  assign pat_w[IBC_UP] = up_code;
  assign len_w[IBC_UP] = up_len;
  assign pat_w[IBC_DN] = dn_code;
  assign len_w[IBC_DN] = dn_len;

  ibc_bit_history #(
    .HIST_W (IBC_CODE_W)
  ) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (t1_mode),
    .accept (bit_valid),
    .bit_in (bit_data),
    .hist_o (hist_w)
  );

  for (genvar c = 0; c < IBC_NUM_CODES; c++) begin : g_match
    ibc_code_matcher #(
      .CNT_W (CNT_W)
    ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (t1_mode),
      .accept  (bit_valid),
      .bit_in  (bit_data),
      .hist    (hist_w),
      .pattern (pat_w[c]),
      .len_sel (len_w[c]),
      .thresh  (match_thresh),
      .hit_o   (hit_w[c]),
      .onset_o (onset_w[c]),
      .count_o (count_w[c])
    );
  end

  ibc_report #(
    .NUM_CODES (IBC_NUM_CODES)
  ) u_report (
    .clk      (clk),
    .rst_n    (rst_n),
    .onset    (onset_w),
    .clr_det  (clr_det),
    .clr_int  (clr_int),
    .int_en   (irq_en),
    .det_stat (det_stat),
    .int_stat (int_stat),
    .irq      (irq)
  );

  // R9: no matching and no detection outside T1 mode
  p_quiet_off_t1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_mode |-> ((onset_w == '0) && (hit_w == '0)));

  // R9: runs are emptied while T1 mode is off
  p_runs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_mode |=> ((count_w[IBC_UP] == '0) && (count_w[IBC_DN] == '0)));

endmodule

// File: tb/inband_code_detect_bench.sv
`timescale 1ns/1ps
module inband_code_detect_bench;

  localparam int CW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          t1_mode, bit_valid, bit_data;
  logic [6:0]    up_code, dn_code;
  logic [1:0]    up_len, dn_len;
  logic [CW-1:0] match_thresh;
  logic [1:0]    irq_en, clr_det, clr_int;
  logic [1:0]    det_stat, int_stat;
  logic          irq;

  inband_code_detect #(.CNT_W(CW)) u_inband_code_detect (
    .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .bit_valid(bit_valid),
    .bit_data(bit_data), .up_code(up_code), .up_len(up_len),
    .dn_code(dn_code), .dn_len(dn_len), .match_thresh(match_thresh),
    .irq_en(irq_en), .clr_det(clr_det), .clr_int(clr_int),
    .det_stat(det_stat), .int_stat(int_stat), .irq(irq)
  );

  typedef struct {
    logic [1:0] det;
    logic [1:0] ist;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;

  // pending configuration, applied at the next driven cycle
  logic       p_t1;
  logic [6:0] p_up_code, p_dn_code;
  logic [1:0] p_up_len, p_dn_len, p_en;
  int         p_thr;

  // reference state
  logic [15:0] mh;
  int          mcnt[2];
  logic [1:0]  mdet, mint;

  // window (newest bit at 0) is a rotation of the L-bit code
  function automatic bit m_rot(logic [15:0] h, logic [6:0] p, int L);
    int mask = (1 << L) - 1;
    int pv   = int'(p) & mask;
    int wv   = int'(h) & mask;
    for (int k = 0; k < L; k++) begin
      int rot = ((pv << k) | (pv >> (L - k))) & mask;
      if (rot == wv) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(input logic b, input logic v, input logic [1:0] cd,
                      input logic [1:0] ci, input string tag);
    exp_t       e;
    logic [1:0] on;
    int         L;
    logic [6:0] pat;
    @(negedge clk);
    t1_mode = p_t1; up_code = p_up_code; up_len = p_up_len;
    dn_code = p_dn_code; dn_len = p_dn_len; irq_en = p_en;
    match_thresh = CW'(p_thr);
    bit_valid = v; bit_data = b; clr_det = cd; clr_int = ci;
    on = 2'b00;
    if (!p_t1) begin
      mh = '0; mcnt[0] = 0; mcnt[1] = 0;
    end else if (v) begin
      mh = {mh[14:0], b};
      for (int c = 0; c < 2; c++) begin
        L   = 4 + int'(c == 0 ? p_up_len : p_dn_len);
        pat = (c == 0) ? p_up_code : p_dn_code;
        if ((mh[0] == mh[L]) && m_rot(mh, pat, L)) begin
          if (mcnt[c] < p_thr) begin
            mcnt[c]++;
            if (mcnt[c] == p_thr) on[c] = 1'b1;
          end
        end else begin
          mcnt[c] = 0;
        end
      end
    end
    mdet = (mdet & ~cd) | on;
    mint = (mint & ~ci) | on;
    e.det = mdet; e.ist = mint; e.irq = |(mint & p_en); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_pat(input logic [6:0] p, input int L, input int ph,
                          input int n, input logic [1:0] cd, input string tag);
    for (int i = 0; i < n; i++) begin
      int idx = L - 1 - ((ph + i) % L);
      step(p[idx], 1'b1, cd, 2'b00, tag);
    end
  endtask

  task automatic spot(input logic [1:0] d, input logic [1:0] s, input logic ir,
                      input string tag);
    @(posedge clk); #3;
    checks++;
    if ({det_stat, int_stat, irq} !== {d, s, ir}) begin
      errors++;
      $display("FAIL %s: det=%b int=%b irq=%b expected det=%b int=%b irq=%b",
               tag, det_stat, int_stat, irq, d, s, ir);
    end
  endtask

  // monitor: compare each expected item one step after it was driven
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({det_stat, int_stat, irq} !== {e.det, e.ist, e.irq}) begin
          errors++;
          $display("FAIL %s: det=%b int=%b irq=%b expected det=%b int=%b irq=%b",
                   e.tag, det_stat, int_stat, irq, e.det, e.ist, e.irq);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    p_t1 = 1'b1; p_up_code = 7'b0000001; p_up_len = 2'd1;
    p_dn_code = 7'b0001001; p_dn_len = 2'd2; p_en = 2'b01; p_thr = 20;
    t1_mode = 1'b1; bit_valid = 1'b0; bit_data = 1'b0;
    up_code = p_up_code; up_len = p_up_len; dn_code = p_dn_code;
    dn_len = p_dn_len; irq_en = p_en; match_thresh = CW'(p_thr);
    clr_det = 2'b00; clr_int = 2'b00;
    mh = '0; mcnt[0] = 0; mcnt[1] = 0; mdet = 2'b00; mint = 2'b00;

    // R1: reset state
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if ({det_stat, int_stat, irq} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset: got %b expected 00000", {det_stat, int_stat, irq});
    end
    @(negedge clk); rst_n = 1'b1;

    // R3 R2: 5-bit activate code 00001 from a shifted phase
    send_pat(7'b0000001, 5, 2, 45, 2'b00, "R3 activate 00001");
    spot(2'b01, 2'b01, 1'b1, "R3 activate detected");

    // R11: clear while the code keeps arriving
    step(1'b0, 1'b0, 2'b01, 2'b01, "R11 clear during code");
    send_pat(7'b0000001, 5, 2, 15, 2'b00, "R11 code continues");
    spot(2'b00, 2'b00, 1'b0, "R11 no repeat report");

    // R10 R4: 001 sent as a doubled 6-bit code, with noisy invalid cycles
    for (int i = 0; i < 50; i++) begin
      step((i % 3) == 2, 1'b1, 2'b00, 2'b00, "R10 doubled 3-bit code");
      step(1'b1, 1'b0, 2'b00, 2'b00, "R4 invalid noise");
    end
    spot(2'b10, 2'b10, 1'b0, "R8 deactivate masked irq");

    // R5: one flipped bit restarts the run
    step(1'b0, 1'b0, 2'b11, 2'b11, "R5 clear");
    send_pat(7'b0000001, 5, 0, 15, 2'b00, "R5 run before flip");
    step(1'b1, 1'b1, 2'b00, 2'b00, "R5 flipped bit");
    send_pat(7'b0000001, 5, 1, 19, 2'b00, "R5 run after flip");
    spot(2'b00, 2'b00, 1'b0, "R5 not yet detected");
    send_pat(7'b0000001, 5, 0, 30, 2'b00, "R5 run completes");
    spot(2'b01, 2'b01, 1'b1, "R5 detected after fresh run");

    // R6 R2: 0101 (upper bits garbage) and 010101 on one 01 stream
    p_up_code = 7'b1110101; p_up_len = 2'd0;
    p_dn_code = 7'b0010101; p_dn_len = 2'd2; p_en = 2'b11;
    step(1'b0, 1'b0, 2'b11, 2'b11, "R6 clear and reprogram");
    send_pat(7'b0000001, 2, 0, 40, 2'b00, "R6 both codes");
    spot(2'b11, 2'b11, 1'b1, "R6 both detected");

    // R2: 7-bit code 1011000
    p_up_code = 7'b1011000; p_up_len = 2'd3;
    step(1'b0, 1'b0, 2'b11, 2'b11, "R2 clear");
    send_pat(7'b1011000, 7, 3, 50, 2'b00, "R2 7-bit code");
    spot(2'b01, 2'b01, 1'b1, "R2 7-bit detected");

    // R7: fresh detection while clr_det is held
    step(1'b1, 1'b1, 2'b00, 2'b01, "R7 break run");
    send_pat(7'b1011000, 7, 5, 30, 2'b01, "R7 set wins over clear");
    spot(2'b00, 2'b01, 1'b1, "R7 int sticky det cleared");

    // R8: enable mask leaves int_stat alone
    p_en = 2'b10;
    step(1'b0, 1'b0, 2'b00, 2'b00, "R8 mask change");
    spot(2'b00, 2'b01, 1'b0, "R8 masked irq");

    // R9: nothing outside T1 mode, history restarts
    p_en = 2'b11; p_t1 = 1'b0;
    step(1'b0, 1'b0, 2'b11, 2'b11, "R9 clear");
    send_pat(7'b1011000, 7, 0, 50, 2'b00, "R9 code with T1 off");
    spot(2'b00, 2'b00, 1'b0, "R9 no detect off T1");
    p_t1 = 1'b1;
    send_pat(7'b1011000, 7, 1, 10, 2'b00, "R9 short run after enable");
    spot(2'b00, 2'b00, 1'b0, "R9 run restarted");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule